// File: doc/BRIEF.md
# Auto-Negotiation Code Word Arbiter

This block settles the operating speed and duplex of a 10/100 twisted-pair link. It works from link code words that an upstream decoder has already pulled out of fast link pulse bursts. It also uses two detection strobes. One reports plain 10BASE-T link pulses and the other reports 100BASE-TX idle. The block holds the local advertisement word, which is the word sent to the partner. It confirms a partner word only after three identical copies arrive, ignoring the acknowledge bit. Resolution then waits for a second confirmed group of three.

After the second group, the block picks the best mode that both sides support. If only link pulses or idle are seen, it takes the detected speed directly at half duplex. This is parallel detection.

Negotiation starts when reset is released, when the link is lost, and when a restart is requested. It is enabled by a strap sampled while reset is held or by a control bit. A fiber-mode input switches it off completely.

Top module: `an_arb_top`

## Requirements
- R1: While and just after reset, `anDone`, `anFault`, `speed100` and `fullDuplex` are 0, `partnerWord` is 0, and `txWord` is the default advertisement 16'h01E1.
- R2: A write (`advWe`=1) loads `advWd` into the advertisement register, and the new value appears on `txWord` on the next cycle.
- R3: A partner word is confirmed after three consecutive identical `rxValid` words. Bit 14 (acknowledge) is ignored in the comparison. `partnerWord` then holds the third word as received, including bit 14.
- R4: A word that differs from the previous one restarts the identical-word count at one, with the new word counted.
- R5: After the first confirmation, `anDone` stays 0 until a second group of three identical words has been received.
- R6: The common abilities are advertisement bits [8:5] ANDed with partner bits [8:5]. Bit 8 is 100 full, bit 7 is 100 half, bit 6 is 10 full and bit 5 is 10 half. Resolution picks the highest set bit in that order and drives `speed100`/`fullDuplex` to match, with `anDone`=1.
- R7: If there is no common ability, `anFault` goes to 1, `anDone` stays 0, and `speed100`/`fullDuplex` stay 0.
- R8: While negotiating, `idleSeen` resolves to 100 half duplex and `nlpSeen` resolves to 10 half duplex, each with `anDone`=1, one cycle later. If both are seen, idle wins.
- R9: While `fiberMode` is 1, `anDone` and `anFault` are 0 and code words have no effect.
- R10: Negotiation runs when `strapAnEn` sampled during reset is 1 or `ctrlAnEn` is 1. When neither holds, words are ignored.
- R11: A pulse on `restartReq` or `linkLoss` clears `anDone`, `anFault`, `speed100`, `fullDuplex` and `partnerWord` on the next cycle, and negotiation starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapAnEn | input | 1 | Enable strap, sampled while reset is held |
| ctrlAnEn | input | 1 | Enable bit from the control register |
| fiberMode | input | 1 | Fiber mode; forces negotiation off |
| restartReq | input | 1 | Restart request pulse |
| linkLoss | input | 1 | Link-loss pulse |
| advWe | input | 1 | Advertisement write strobe |
| advWd | input | 16 | Advertisement write data |
| rxValid | input | 1 | Decoded partner word strobe |
| rxWord | input | 16 | Decoded partner code word |
| nlpSeen | input | 1 | Normal link pulses detected |
| idleSeen | input | 1 | 100BASE-TX idle detected |
| txWord | output | 16 | Word advertised to the partner |
| partnerWord | output | 16 | Confirmed partner ability word |
| speed100 | output | 1 | Resolved speed: 1 = 100 Mb/s |
| fullDuplex | output | 1 | Resolved duplex: 1 = full |
| anDone | output | 1 | Resolution complete |
| anFault | output | 1 | No common ability |

## Verification
The assertions take the restart, link-loss and fiber inputs to be synchronous to `clk`. The stability check also assumes that while a result is held, `ctrlAnEn` is 1 and none of these inputs is asserted. The bench drives every input on the falling edge. It pulses restart, link loss and the detection strobes for exactly one cycle. It keeps `ctrlAnEn` at 1 in every stretch where a held result is observed, except the strap-enable case, where no restart arrives while the result is held.

// File: rtl/an_arb_pkg.sv
package an_arb_pkg;
  localparam int WORD_W    = 16;
  localparam int ACK_BIT   = 14;
  localparam int ABIL_LSB  = 5;
  localparam int ABIL_W    = 4;
  localparam int GROUP_LEN = 3;
  localparam int CNT_W     = $clog2(GROUP_LEN + 1);
  localparam logic [WORD_W-1:0] ADV_RESET = 16'h01E1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NEG1, ST_NEG2, ST_DONE, ST_FAULT
  } anState_t;

  typedef struct packed {
    logic clrAll;
    logic countEn;
    logic clrCount;
    logic storePartner;
    logic resolveAn;
    logic pdIdle;
    logic pdNlp;
  } anStrobe_t;
endpackage

// File: rtl/an_arb_dp.sv
module an_arb_dp
  import an_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  anStrobe_t         strb,
  input  logic              advWe,
  input  logic [WORD_W-1:0] advWd,
  input  logic              rxValid,
  input  logic [WORD_W-1:0] rxWord,
  output logic              groupHit,
  output logic              hasCommon,
  output logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] partnerWord,
  output logic              speed100,
  output logic              fullDuplex
);
  localparam logic [WORD_W-1:0] ACK_MASK = WORD_W'(1) << ACK_BIT;
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(GROUP_LEN - 1);

  logic [WORD_W-1:0] advReg, lastWord, maskedWord;
  logic [CNT_W-1:0]  sameCnt;
  logic [ABIL_W-1:0] commonAbil;
  logic              wordMatch;

  assign maskedWord = rxWord & ~ACK_MASK;
  assign wordMatch  = (sameCnt != '0) && (maskedWord == lastWord);
  assign groupHit   = rxValid && strb.countEn && wordMatch && (sameCnt == LAST_CNT);
  assign commonAbil = advReg[ABIL_LSB +: ABIL_W] & partnerWord[ABIL_LSB +: ABIL_W];
  assign hasCommon  = |commonAbil;
  assign txWord     = advReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) advReg <= ADV_RESET;
    else if (advWe) advReg <= advWd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sameCnt  <= '0;
      lastWord <= '0;
    end else if (strb.clrAll || strb.clrCount) begin
      sameCnt  <= '0;
    end else if (rxValid && strb.countEn) begin
      if (wordMatch) begin
        if (sameCnt != CNT_W'(GROUP_LEN)) sameCnt <= sameCnt + 1'b1;
      end else begin
        sameCnt  <= CNT_W'(1);
        lastWord <= maskedWord;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partnerWord <= '0;
      speed100    <= 1'b0;
      fullDuplex  <= 1'b0;
    end else if (strb.clrAll) begin
      partnerWord <= '0;
      speed100    <= 1'b0;
      fullDuplex  <= 1'b0;
    end else begin
      if (strb.storePartner) partnerWord <= rxWord;
      if (strb.pdIdle) begin
        speed100   <= 1'b1;
        fullDuplex <= 1'b0;
      end else if (strb.pdNlp) begin
        speed100   <= 1'b0;
        fullDuplex <= 1'b0;
      end else if (strb.resolveAn) begin
        priority casez (commonAbil)
          4'b1???: begin speed100 <= 1'b1; fullDuplex <= 1'b1; end
          4'b01??: begin speed100 <= 1'b1; fullDuplex <= 1'b0; end
          4'b001?: begin speed100 <= 1'b0; fullDuplex <= 1'b1; end
          default: begin speed100 <= 1'b0; fullDuplex <= 1'b0; end
        endcase
      end
    end
  end
endmodule

// File: rtl/an_arb_ctrl.sv
module an_arb_ctrl
  import an_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      strapAnEn,
  input  logic      ctrlAnEn,
  input  logic      fiberMode,
  input  logic      restartReq,
  input  logic      linkLoss,
  input  logic      nlpSeen,
  input  logic      idleSeen,
  input  logic      groupHit,
  input  logic      hasCommon,
  output anStrobe_t strb,
  output logic      anDone,
  output logic      anFault
);
  anState_t state, nextState;
  logic strapLatch, anEnable;

  always_ff @(posedge clk) begin
    if (!rstN) strapLatch <= strapAnEn;
  end

  assign anEnable = (strapLatch || ctrlAnEn) && !fiberMode;

  always_comb begin
    strb      = '0;
    nextState = state;
    if (!anEnable) begin
      nextState   = ST_IDLE;
      strb.clrAll = 1'b1;
    end else if (restartReq || linkLoss || state == ST_IDLE) begin
      nextState   = ST_NEG1;
      strb.clrAll = 1'b1;
    end else if (state == ST_NEG1 || state == ST_NEG2) begin
      strb.countEn = 1'b1;
      if (idleSeen) begin
        strb.pdIdle = 1'b1;
        nextState   = ST_DONE;
      end else if (nlpSeen) begin
        strb.pdNlp = 1'b1;
        nextState  = ST_DONE;
      end else if (groupHit) begin
        if (state == ST_NEG1) begin
          strb.storePartner = 1'b1;
          strb.clrCount     = 1'b1;
          nextState         = ST_NEG2;
        end else if (hasCommon) begin
          strb.resolveAn = 1'b1;
          nextState      = ST_DONE;
        end else begin
          nextState = ST_FAULT;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign anDone  = (state == ST_DONE);
  assign anFault = (state == ST_FAULT);
endmodule

// File: rtl/an_arb_top.sv
module an_arb_top
  import an_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapAnEn,
  input  logic              ctrlAnEn,
  input  logic              fiberMode,
  input  logic              restartReq,
  input  logic              linkLoss,
  input  logic              advWe,
  input  logic [WORD_W-1:0] advWd,
  input  logic              rxValid,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              nlpSeen,
  input  logic              idleSeen,
  output logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] partnerWord,
  output logic              speed100,
  output logic              fullDuplex,
  output logic              anDone,
  output logic              anFault
);
  anStrobe_t strb;
  logic groupHit, hasCommon;

  an_arb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .strapAnEn(strapAnEn), .ctrlAnEn(ctrlAnEn),
    .fiberMode(fiberMode), .restartReq(restartReq), .linkLoss(linkLoss),
    .nlpSeen(nlpSeen), .idleSeen(idleSeen), .groupHit(groupHit),
    .hasCommon(hasCommon), .strb(strb), .anDone(anDone), .anFault(anFault)
  );

  an_arb_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .advWe(advWe), .advWd(advWd),
    .rxValid(rxValid), .rxWord(rxWord), .groupHit(groupHit),
    .hasCommon(hasCommon), .txWord(txWord), .partnerWord(partnerWord),
    .speed100(speed100), .fullDuplex(fullDuplex)
  );
endmodule

// File: rtl/an_arb_chk.sv
module an_arb_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ctrlAnEn,
  input logic        fiberMode,
  input logic        restartReq,
  input logic        linkLoss,
  input logic [15:0] partnerWord,
  input logic        speed100,
  input logic        fullDuplex,
  input logic        anDone,
  input logic        anFault
);
  // R7
  done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(anDone && anFault));

  // R9
  fiber_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    fiberMode |=> (!anDone && !anFault));

  // R11
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restartReq || linkLoss) |=> (!anDone && !anFault && partnerWord == 16'h0));

  // R7
  fault_no_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    anFault |-> (!speed100 && !fullDuplex));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anDone && ctrlAnEn && !restartReq && !linkLoss && !fiberMode) |=>
      (anDone && $stable(partnerWord) && $stable(speed100) && $stable(fullDuplex)));
endmodule

bind an_arb_top an_arb_chk i_chk (
  .clk(clk), .rstN(rstN), .ctrlAnEn(ctrlAnEn), .fiberMode(fiberMode),
  .restartReq(restartReq), .linkLoss(linkLoss), .partnerWord(partnerWord),
  .speed100(speed100), .fullDuplex(fullDuplex), .anDone(anDone), .anFault(anFault)
);

// File: tb/test_an_arb_top.sv
module test_an_arb_top;
  logic clk = 1'b0;
  logic rstN, strapAnEn, ctrlAnEn, fiberMode, restartReq, linkLoss;
  logic advWe, rxValid, nlpSeen, idleSeen;
  logic [15:0] advWd, rxWord, txWord, partnerWord;
  logic speed100, fullDuplex, anDone, anFault;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  an_arb_top i_an_arb_top (
    .clk(clk), .rstN(rstN), .strapAnEn(strapAnEn), .ctrlAnEn(ctrlAnEn),
    .fiberMode(fiberMode), .restartReq(restartReq), .linkLoss(linkLoss),
    .advWe(advWe), .advWd(advWd), .rxValid(rxValid), .rxWord(rxWord),
    .nlpSeen(nlpSeen), .idleSeen(idleSeen), .txWord(txWord),
    .partnerWord(partnerWord), .speed100(speed100), .fullDuplex(fullDuplex),
    .anDone(anDone), .anFault(anFault)
  );

  // {adv abilities[3:0], partner abilities[3:0], speed, duplex, done, fault}
  localparam logic [11:0] VEC [6] = '{
    {4'b1111, 4'b1111, 4'b1110},
    {4'b1111, 4'b0100, 4'b1010},
    {4'b0011, 4'b1110, 4'b0110},
    {4'b1101, 4'b0011, 4'b0010},
    {4'b1000, 4'b0111, 4'b0001},
    {4'b0110, 4'b0110, 4'b1010}
  };

  function automatic logic [15:0] mkWord(input logic [3:0] abil);
    return {7'b0, abil, 5'b00001};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic status(input string req, input logic [3:0] exp);
    chk(req, {28'b0, speed100, fullDuplex, anDone, anFault}, {28'b0, exp});
  endtask

  task automatic sendWord(input logic [15:0] w);
    @(negedge clk); rxWord = w; rxValid = 1'b1;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); restartReq = 1'b1;
    @(negedge clk); restartReq = 1'b0;
  endtask

  task automatic writeAdv(input logic [15:0] w);
    @(negedge clk); advWe = 1'b1; advWd = w;
    @(negedge clk); advWe = 1'b0;
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk); rstN = 1'b0; strapAnEn = strap;
    repeat (3) @(negedge clk);
    rstN = 1'b1; strapAnEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; strapAnEn = 1'b0; ctrlAnEn = 1'b0; fiberMode = 1'b0;
    restartReq = 1'b0; linkLoss = 1'b0; advWe = 1'b0; advWd = '0;
    rxValid = 1'b0; rxWord = '0; nlpSeen = 1'b0; idleSeen = 1'b0;
    doReset(1'b0);
    // R1 reset state
    status("R1 status", 4'b0000);
    chk("R1 partnerWord", {16'b0, partnerWord}, 32'h0);
    chk("R1 txWord", {16'b0, txWord}, 32'h01E1);

    // R10 disabled: words ignored
    for (int i = 0; i < 6; i++) sendWord(16'h01E1);
    status("R10 disabled status", 4'b0000);
    chk("R10 disabled partner", {16'b0, partnerWord}, 32'h0);
    @(negedge clk); ctrlAnEn = 1'b1;
    @(negedge clk);

    // Table: R2, R3, R5, R6, R7
    for (int v = 0; v < 6; v++) begin
      logic [15:0] advW, parW;
      advW = mkWord(VEC[v][11:8]);
      parW = mkWord(VEC[v][7:4]);
      writeAdv(advW);
      chk("R2 txWord", {16'b0, txWord}, {16'b0, advW});
      restart();
      sendWord(parW | 16'h4000);
      sendWord(parW);
      sendWord(parW | 16'h4000);
      chk("R3 partner after group", {16'b0, partnerWord}, {16'b0, parW | 16'h4000});
      status("R5 no result after first group", 4'b0000);
      for (int k = 0; k < 3; k++) sendWord(parW);
      status(VEC[v][0] ? "R7 fault" : "R6 resolve", VEC[v][3:0]);
    end

    // R4 mismatch restarts count
    writeAdv(16'h01E1);
    restart();
    sendWord(mkWord(4'b1000));
    sendWord(mkWord(4'b1000));
    sendWord(mkWord(4'b0100));
    sendWord(mkWord(4'b0100));
    chk("R4 not yet confirmed", {16'b0, partnerWord}, 32'h0);
    sendWord(mkWord(4'b0100));
    chk("R4 confirmed new word", {16'b0, partnerWord}, {16'b0, mkWord(4'b0100)});

    // R8 parallel detection
    restart();
    @(negedge clk); idleSeen = 1'b1;
    @(negedge clk); idleSeen = 1'b0;
    status("R8 idle", 4'b1010);
    restart();
    @(negedge clk); nlpSeen = 1'b1;
    @(negedge clk); nlpSeen = 1'b0;
    status("R8 nlp", 4'b0010);
    restart();
    @(negedge clk); nlpSeen = 1'b1; idleSeen = 1'b1;
    @(negedge clk); nlpSeen = 1'b0; idleSeen = 1'b0;
    status("R8 both idle wins", 4'b1010);

    // R11 link loss clears
    @(negedge clk); linkLoss = 1'b1;
    @(negedge clk); linkLoss = 1'b0;
    status("R11 link loss", 4'b0000);
    for (int k = 0; k < 6; k++) sendWord(mkWord(4'b0010));
    status("R11 renegotiated", 4'b0110);
    restart();
    chk("R11 restart clears partner", {16'b0, partnerWord}, 32'h0);

    // R9 fiber mode
    @(negedge clk); fiberMode = 1'b1;
    for (int k = 0; k < 6; k++) sendWord(mkWord(4'b1000));
    status("R9 fiber", 4'b0000);
    chk("R9 fiber partner", {16'b0, partnerWord}, 32'h0);
    @(negedge clk); fiberMode = 1'b0;

    // R10 strap enable path
    ctrlAnEn = 1'b0;
    doReset(1'b1);
    @(negedge clk);
    for (int k = 0; k < 6; k++) sendWord(mkWord(4'b1000));
    status("R10 strap enable", 4'b1110);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule